// File: doc/BRIEF.md
# Stride-Congruence Memory Self-Test Engine

This block tests a synchronous single-port memory that sits outside it. It steps a starting offset through every value from zero to one less than a fixed stride. For each offset it writes the whole memory one or more times. A location whose address differs from the offset by a multiple of the stride receives a test pattern, and every other location receives the bitwise complement. After the writes, a separate pass reads back only the congruent locations and compares them with the pattern. Each write pass and each read pass covers the memory completely before the next one starts. This keeps any buffering in the memory path from hiding a fault.

Software or a boot sequencer places a pattern and a write-repeat count on the inputs and pulses `start`. The engine holds `busy` until it finishes and then pulses `done`. Any mismatch raises a sticky `fail` flag and records the address, the expected word and the actual word of the first mismatch. The sweep still runs to the end. The memory must be at least as deep as the stride.

Top module: `stride_mem_tester`

## Requirements
- R1: While reset is asserted and on leaving reset, `busy`, `done`, `fail`, `mem_en` and `mem_we` are all 0.
- R2: Offsets are processed in ascending order from 0 to STRIDE-1. For each offset, all of that offset's write passes finish before its read pass begins, and the read pass finishes before the next offset's writes begin.
- R3: Each write pass writes addresses 0 to DEPTH-1 in ascending order, one per cycle with `mem_en`=1 and `mem_we`=1. The data is the latched pattern when (address mod STRIDE) equals the current offset, and the bitwise inverse of the pattern otherwise. After a complete run, the memory therefore holds the pattern where address mod STRIDE = STRIDE-1 and the inverse everywhere else.
- R4: The number of write passes per offset equals `repeat_cnt` as sampled at start, and a value of 0 gives one pass. A run therefore issues STRIDE*DEPTH*max(repeat_cnt,1) writes.
- R5: The read pass issues reads (`mem_en`=1, `mem_we`=0) at offset, offset+STRIDE, offset+2*STRIDE, and so on, stopping at the last such address that is no greater than DEPTH-1. No writes occur during it. Over a full run, every address is read exactly once.
- R6: Read data arrives on `mem_rdata` one cycle after the read is issued and is compared with the pattern. The first mismatch sets `fail` and records `fail_addr`, `fail_exp` and `fail_act`. The flag stays set, and later mismatches do not change the recorded values.
- R7: A mismatch does not shorten the run: every write and read of the sweep is still issued, and `done` still arrives.
- R8: `busy` rises in the cycle after an accepted `start`. `done` is a single-cycle pulse that follows the read pass of the final offset, and `busy` is 0 while `done` is 1.
- R9: A `start` accepted while idle clears `fail` and the recorded failure values, so a clean run reports `fail`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a run when idle |
| pattern | input | DW | Test word, latched at start |
| repeat_cnt | input | RW | Write passes per offset (0 counts as 1), latched at start |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid one cycle after a read |
| fail | output | 1 | Sticky mismatch flag |
| fail_addr | output | AW | Address of the first mismatch |
| fail_exp | output | DW | Expected word at the first mismatch |
| fail_act | output | DW | Word actually read at the first mismatch |

## Verification
The bench first checks that the running phase counter agrees with address mod stride at every write. If the counter is seeded wrongly when a new offset or a repeated pass starts, the pattern lands on the wrong locations. It also checks that the read pass stops at the last address below the top of memory, since an off-by-one there would read past the end or skip the final strided location. Two stuck faults are placed so that the one at the higher address is found first. A design that latched the lowest failing address, or overwrote its record on a later mismatch, would report the wrong location. Runs with a repeat count of 0 and of 2 test the pass counting, and a clean run after a failing one shows whether a new start clears the sticky state.

// File: rtl/stride_mem_tester.sv
module stride_mem_tester #(
  parameter int DEPTH  = 64,
  parameter int DW     = 16,
  parameter int STRIDE = 20,
  parameter int RW     = 4,
  localparam int AW    = $clog2(DEPTH),
  localparam int SW    = $clog2(STRIDE)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] pattern,
  input  logic [RW-1:0] repeat_cnt,
  output logic          busy,
  output logic          done,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          fail,
  output logic [AW-1:0] fail_addr,
  output logic [DW-1:0] fail_exp,
  output logic [DW-1:0] fail_act
);

  localparam logic [AW-1:0] LAST   = AW'(DEPTH - 1);
  localparam logic [SW-1:0] STR_M1 = SW'(STRIDE - 1);

  typedef enum logic [1:0] {IDLE, WRITE, CHECK, DRAIN} st_t;

  st_t           st;
  logic [AW-1:0] addr;
  logic [SW-1:0] phase;
  logic [SW-1:0] offset;
  logic [RW-1:0] pass_rem;
  logic [RW-1:0] rep_q;
  logic [DW-1:0] pat_q;
  logic          rd_pend;
  logic [AW-1:0] rd_addr;
  logic [AW:0]   nxt_raddr;
  logic          rd_last;
  logic          go;

  function automatic logic [SW-1:0] phase0(input logic [SW-1:0] o);
    return (o == '0) ? '0 : SW'(STRIDE) - o;
  endfunction

  function automatic logic [RW-1:0] extra_passes(input logic [RW-1:0] r);
    return (r == '0) ? '0 : r - 1'b1;
  endfunction

  assign go        = start && (st == IDLE);
  assign nxt_raddr = {1'b0, addr} + (AW+1)'(STRIDE);
  assign rd_last   = nxt_raddr > {1'b0, LAST};

  assign busy      = (st != IDLE);
  assign mem_en    = (st == WRITE) || (st == CHECK);
  assign mem_we    = (st == WRITE);
  assign mem_addr  = addr;
  assign mem_wdata = (phase == '0) ? pat_q : ~pat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= IDLE;
      addr     <= '0;
      phase    <= '0;
      offset   <= '0;
      pass_rem <= '0;
      rep_q    <= '0;
      pat_q    <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        IDLE: if (start) begin
          st       <= WRITE;
          addr     <= '0;
          phase    <= '0;
          offset   <= '0;
          pat_q    <= pattern;
          rep_q    <= repeat_cnt;
          pass_rem <= extra_passes(repeat_cnt);
        end
        WRITE: begin
          addr  <= addr + 1'b1;
          phase <= (phase == STR_M1) ? '0 : phase + 1'b1;
          if (addr == LAST) begin
            if (pass_rem != '0) begin
              pass_rem <= pass_rem - 1'b1;
              addr     <= '0;
              phase    <= phase0(offset);
            end else begin
              st   <= CHECK;
              addr <= AW'(offset);
            end
          end
        end
        CHECK: begin
          if (rd_last) st <= DRAIN;
          else         addr <= nxt_raddr[AW-1:0];
        end
        DRAIN: begin
          if (offset == STR_M1) begin
            st   <= IDLE;
            done <= 1'b1;
          end else begin
            st       <= WRITE;
            offset   <= offset + 1'b1;
            addr     <= '0;
            phase    <= phase0(offset + 1'b1);
            pass_rem <= extra_passes(rep_q);
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pend   <= 1'b0;
      rd_addr   <= '0;
      fail      <= 1'b0;
      fail_addr <= '0;
      fail_exp  <= '0;
      fail_act  <= '0;
    end else begin
      rd_pend <= (st == CHECK);
      rd_addr <= addr;
      if (go) begin
        fail      <= 1'b0;
        fail_addr <= '0;
        fail_exp  <= '0;
        fail_act  <= '0;
      end else if (rd_pend && (mem_rdata != pat_q) && !fail) begin
        fail      <= 1'b1;
        fail_addr <= rd_addr;
        fail_exp  <= pat_q;
        fail_act  <= mem_rdata;
      end
    end
  end

  // R3
  wdata_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ((mem_wdata == pat_q) == ((int'(addr) % STRIDE) == int'(offset))));

  // R5
  read_stride_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !mem_we) |-> ((int'(addr) % STRIDE) == int'(offset)));

  // R6
  fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !go) |=> (fail && $stable(fail_addr) && $stable(fail_act)));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

// File: tb/test_stride_mem_tester.sv
module test_stride_mem_tester;
  localparam int DEPTH = 64, DW = 16, STRIDE = 20, RW = 4, AW = 6;

  logic          clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [DW-1:0] pattern = '0;
  logic [RW-1:0] repeat_cnt = '0;
  logic          busy, done, mem_en, mem_we, fail;
  logic [AW-1:0] mem_addr, fail_addr;
  logic [DW-1:0] mem_wdata, fail_exp, fail_act;
  logic [DW-1:0] mem_rdata = '0;

  int checks = 0, errors = 0;
  int passes = 1, wcnt = 0, rcnt = 0, roff = 0, exp_ra = 0, done_cnt = 0;
  logic [DW-1:0] pat = '0;
  logic fault_on = 1'b0, prev_done = 1'b0;
  logic [DW-1:0] mem [0:DEPTH-1];

  always #4 clk = ~clk;

  stride_mem_tester #(.DEPTH(DEPTH), .DW(DW), .STRIDE(STRIDE), .RW(RW)) i_stride_mem_tester (
    .clk(clk), .rst_n(rst_n), .start(start), .pattern(pattern), .repeat_cnt(repeat_cnt),
    .busy(busy), .done(done), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .fail(fail), .fail_addr(fail_addr),
    .fail_exp(fail_exp), .fail_act(fail_act));

  function automatic logic [DW-1:0] stuck(input logic [AW-1:0] a);
    return (fault_on && (a == 6'd45 || a == 6'd10)) ? 16'h0001 : 16'h0000;
  endfunction

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr] | stuck(mem_addr);
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_en && mem_we) begin
        int off;
        logic [DW-1:0] ew;
        off = wcnt / (DEPTH * passes);
        ew = ((int'(mem_addr) % STRIDE) == off) ? pat : ~pat;
        chk(int'(mem_addr) == wcnt % DEPTH, "R3", "write address", 32'(mem_addr), 32'(wcnt % DEPTH));
        chk(mem_wdata == ew, "R3", "write data", 32'(mem_wdata), 32'(ew));
        wcnt++;
      end
      if (mem_en && !mem_we) begin
        chk(int'(mem_addr) == exp_ra, "R5", "read address", 32'(mem_addr), 32'(exp_ra));
        chk(wcnt == (roff + 1) * DEPTH * passes, "R2", "writes before read", 32'(wcnt),
            32'((roff + 1) * DEPTH * passes));
        rcnt++;
        if (exp_ra + STRIDE <= DEPTH - 1) exp_ra += STRIDE;
        else begin roff++; exp_ra = roff; end
      end
      if (done) begin
        done_cnt++;
        chk(!prev_done, "R8", "done width", 32'(prev_done), 32'd0);
        chk(!busy, "R8", "busy with done", 32'(busy), 32'd0);
      end
      prev_done = done;
    end
  end

  task automatic run(input logic [DW-1:0] p, input logic [RW-1:0] r);
    int cyc;
    pat = p; passes = (r == 0) ? 1 : int'(r);
    wcnt = 0; rcnt = 0; roff = 0; exp_ra = 0; done_cnt = 0;
    @(negedge clk);
    pattern = p; repeat_cnt = r; start = 1'b1;
    @(negedge clk);
    start = 1'b0; pattern = ~p; repeat_cnt = 4'd7;
    chk(busy == 1'b1, "R8", "busy after start", 32'(busy), 32'd1);
    cyc = 0;
    while (!done && cyc < 50000) begin @(negedge clk); cyc++; end
    if (!done) chk(1'b0, "R8", "watchdog, no done", 32'(cyc), 32'd50000);
    @(negedge clk);
    chk(done_cnt == 1, "R8", "done pulses", 32'(done_cnt), 32'd1);
    chk(!busy, "R8", "idle after done", 32'(busy), 32'd0);
    chk(wcnt == STRIDE * DEPTH * passes, "R4", "write count", 32'(wcnt), 32'(STRIDE * DEPTH * passes));
    chk(rcnt == DEPTH, "R5", "read count", 32'(rcnt), 32'(DEPTH));
    chk(roff == STRIDE, "R2", "offsets covered", 32'(roff), 32'(STRIDE));
    for (int a = 0; a < DEPTH; a++) begin
      logic [DW-1:0] e;
      e = (a % STRIDE == STRIDE - 1) ? p : ~p;
      chk(mem[a] == e, "R3", "final image", 32'(mem[a]), 32'(e));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !fail && !mem_en && !mem_we, "R1", "in reset",
        {27'd0, busy, done, fail, mem_en, mem_we}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !fail && !mem_en && !mem_we, "R1", "after reset",
        {27'd0, busy, done, fail, mem_en, mem_we}, 32'd0);

    run(16'h00FF, 4'd0);
    chk(!fail, "R6", "clean run, zero repeat", 32'(fail), 32'd0);
    run(16'hA5C3, 4'd2);
    chk(!fail, "R6", "clean run, two passes", 32'(fail), 32'd0);

    fault_on = 1'b1;
    run(16'h1234, 4'd1);
    chk(fail, "R6", "fault flagged", 32'(fail), 32'd1);
    chk(fail_addr == 6'd45, "R6", "first fail address", 32'(fail_addr), 32'd45);
    chk(fail_exp == 16'h1234, "R6", "expected word", 32'(fail_exp), 32'h1234);
    chk(fail_act == 16'h1235, "R6", "actual word", 32'(fail_act), 32'h1235);
    chk(wcnt == STRIDE * DEPTH, "R7", "sweep completed after fault", 32'(wcnt), 32'(STRIDE * DEPTH));

    fault_on = 1'b0;
    run(16'hFFFF, 4'd1);
    chk(!fail, "R9", "fail cleared by new start", 32'(fail), 32'd0);
    chk(fail_addr == '0, "R9", "fail address cleared", 32'(fail_addr), 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule